// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an on-chip requester and an external asynchronous static RAM. Each request carries a direction bit, a word address and, for writes, a data word. The controller turns one request into one memory access. It drives the active-low chip-enable, output-enable and write-enable strobes and the address bus. It also drives a tri-stated bidirectional data bus. A read returns its word through a registered data output, together with a single-cycle valid pulse.

The memory's timing limits are given as parameters in picoseconds, alongside the clock period. Every strobe width, wait and turnaround gap is converted to a whole number of clock cycles at elaboration, so the same RTL fits any clock rate. The state machine has five states:

- `ST_IDLE` accepts a request when `req` is high.
- `ST_RD_ACC` holds chip-enable and output-enable low. When its count runs out it samples the bus and moves to `ST_RD_TURN`.
- `ST_RD_TURN` keeps every strobe high while the memory's drivers switch off, then returns to `ST_IDLE`.
- `ST_WR_PULSE` holds chip-enable and write-enable low while the controller drives the data bus. When its count runs out it moves to `ST_WR_REC`.
- `ST_WR_REC` has write-enable high, chip-enable low and the bus released. It fills out the write cycle time, then returns to `ST_IDLE`.

Top module: `async_sram_ctl`

## Requirements
- R1: While and directly after reset, all three strobes are high, `ready` is high, `rd_valid` is low and the controller does not drive `sram_dq`.
- R2: A read holds `sram_ce_n` and `sram_oe_n` low together for exactly RD = max(ceil(tAA), ceil(tACE), ceil(tDOE), ceil(tRC), 1) cycles, with `sram_we_n` high. A limit L is converted to ceil(L / CLK_PS) cycles, and a nonzero L gives at least one cycle.
- R3: The read word is sampled at the clock edge that ends the strobe window. `rd_valid` is high for exactly one cycle, the cycle after that edge, and `rd_data` then holds the sampled word.
- R4: After a read, at least TURN = max(ceil(tHZOE), 1) cycles with `sram_oe_n` high pass before the controller next pulls `sram_we_n` low.
- R5: A write holds `sram_ce_n` and `sram_we_n` low together for exactly WP = max(ceil(tPWE), ceil(tAW), ceil(tSD), 1) cycles. The write word is driven on `sram_dq` throughout, and `sram_oe_n` stays high for the whole write.
- R6: A write ends on the rise of `sram_we_n` while `sram_ce_n` is still low. The bus is released on that same edge. `sram_ce_n` then stays low for REC = ceil(tWC) - WP cycles (at least 1) before it rises.
- R7: `ready` is low from the edge that accepts a request until the access completes. It returns high RD+TURN cycles after a read is accepted and WP+REC cycles after a write is accepted. A request raised while `ready` is low is ignored and starts no access.
- R8: `sram_addr` does not change while `sram_ce_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PS |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, taken when `ready` is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| ready | output | 1 | High when a new request can be taken |
| rd_valid | output | 1 | One-cycle pulse marking a new `rd_data` |
| rd_data | output | DATA_W | Registered read word |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_dq | inout | DATA_W | Memory data bus, tri-stated |

## Verification
The hardest case to reach from the ports is the turnaround from a read to a write. The memory must have stopped driving before the controller drives, and this only matters when a write request arrives the moment `ready` returns after a read. The bench issues a write straight after every read in an interleaved sweep. It counts the cycles between the rise of output-enable and the next fall of write-enable. It also models the memory's late output by returning corrupted data until the strobes have been low long enough, so sampling one cycle early is caught.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_REC   = 3'd4
    } sram_st_e;

    // Ceiling conversion of a limit in picoseconds to clock cycles.
    function automatic int unsigned ps_to_cyc(input int unsigned lim_ps,
                                              input int unsigned per_ps);
        if (lim_ps == 0) return 0;
        return (lim_ps + per_ps - 1) / per_ps;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned RD_CYC   = 3,
    parameter int unsigned TURN_CYC = 2,
    parameter int unsigned WP_CYC   = 2,
    parameter int unsigned REC_CYC  = 1,
    parameter int unsigned CNT_W    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic req_wr,
    output logic ready,
    output logic accept,
    output logic capture,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic dq_drive
);

    sram_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_done;

    assign cnt_done = (cnt_q == '0);

    // Next-state and counter reload
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req) begin
                    if (req_wr) begin
                        st_d  = ST_WR_PULSE;
                        cnt_d = CNT_W'(WP_CYC - 1);
                    end else begin
                        st_d  = ST_RD_ACC;
                        cnt_d = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (cnt_done) begin
                    st_d  = ST_RD_TURN;
                    cnt_d = CNT_W'(TURN_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_RD_TURN: begin
                if (cnt_done) st_d = ST_IDLE;
                else          cnt_d = cnt_q - 1'b1;
            end
            ST_WR_PULSE: begin
                if (cnt_done) begin
                    st_d  = ST_WR_REC;
                    cnt_d = CNT_W'(REC_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WR_REC: begin
                if (cnt_done) st_d = ST_IDLE;
                else          cnt_d = cnt_q - 1'b1;
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Output decode
    always_comb begin
        ready    = 1'b0;
        accept   = 1'b0;
        capture  = 1'b0;
        ce_n     = 1'b1;
        oe_n     = 1'b1;
        we_n     = 1'b1;
        dq_drive = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                ready  = 1'b1;
                accept = req;
            end
            ST_RD_ACC: begin
                ce_n    = 1'b0;
                oe_n    = 1'b0;
                capture = cnt_done;
            end
            ST_RD_TURN: begin
            end
            ST_WR_PULSE: begin
                ce_n     = 1'b0;
                we_n     = 1'b0;
                dq_drive = 1'b1;
            end
            ST_WR_REC: begin
                ce_n = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assert_oe_we_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    assert_we_rise_ce_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> !ce_n);

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= bus_in;
        end
    end

    assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_q |=> !rvalid_q);

endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CLK_PS    = 4000,
    parameter int unsigned T_RC_PS   = 10000,
    parameter int unsigned T_AA_PS   = 10000,
    parameter int unsigned T_ACE_PS  = 10000,
    parameter int unsigned T_DOE_PS  = 5000,
    parameter int unsigned T_HZOE_PS = 5000,
    parameter int unsigned T_WC_PS   = 10000,
    parameter int unsigned T_PWE_PS  = 7000,
    parameter int unsigned T_AW_PS   = 7000,
    parameter int unsigned T_SD_PS   = 6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DATA_W-1:0] sram_dq
);

    localparam int unsigned C_RD_RAW = umax(umax(ps_to_cyc(T_AA_PS, CLK_PS),
                                                 ps_to_cyc(T_ACE_PS, CLK_PS)),
                                            umax(ps_to_cyc(T_DOE_PS, CLK_PS),
                                                 ps_to_cyc(T_RC_PS, CLK_PS)));
    localparam int unsigned RD_CYC   = umax(C_RD_RAW, 1);
    localparam int unsigned TURN_CYC = umax(ps_to_cyc(T_HZOE_PS, CLK_PS), 1);
    localparam int unsigned WP_CYC   = umax(umax(ps_to_cyc(T_PWE_PS, CLK_PS),
                                                 ps_to_cyc(T_AW_PS, CLK_PS)),
                                            umax(ps_to_cyc(T_SD_PS, CLK_PS), 1));
    localparam int unsigned C_WC     = ps_to_cyc(T_WC_PS, CLK_PS);
    localparam int unsigned REC_CYC  = (C_WC > WP_CYC + 1) ? (C_WC - WP_CYC) : 1;
    localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, TURN_CYC), umax(WP_CYC, REC_CYC));
    localparam int unsigned CNT_W    = umax($clog2(MAX_CYC + 1), 1);

    logic              accept, capture, dq_drive;
    logic [DATA_W-1:0] wdata_q;

    sram_ctl_fsm #(
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .WP_CYC   (WP_CYC),
        .REC_CYC  (REC_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wr   (req_wr),
        .ready    (ready),
        .accept   (accept),
        .capture  (capture),
        .ce_n     (sram_ce_n),
        .oe_n     (sram_oe_n),
        .we_n     (sram_we_n),
        .dq_drive (dq_drive)
    );

    sram_ctl_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_in    (sram_dq),
        .addr_q    (sram_addr),
        .wdata_q   (wdata_q),
        .rdata_q   (rd_data),
        .rvalid_q  (rd_valid)
    );

    assign sram_dq = dq_drive ? wdata_q : 'z;

    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    assert_drive_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> (!sram_we_n && !sram_ce_n && sram_oe_n));

endmodule

// File: tb/sim_async_sram_ctl.sv
module sim_async_sram_ctl;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int PER = 4000;

    function automatic int cdiv(input int x);
        return (x == 0) ? 0 : (x + PER - 1) / PER;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD   = mx(mx(cdiv(10000), cdiv(5000)), 1);
    localparam int E_TURN = mx(cdiv(5000), 1);
    localparam int E_WP   = mx(mx(cdiv(7000), cdiv(6000)), 1);
    localparam int E_REC  = mx(cdiv(10000) - E_WP, 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready, rd_valid, ce_n, oe_n, we_n;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] sram_addr;
    wire  [DW-1:0] dq;

    int tests = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    async_sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(PER)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_ce_n(ce_n),
        .sram_oe_n(oe_n), .sram_we_n(we_n), .sram_addr(sram_addr),
        .sram_dq(dq));

    // Memory model: data only becomes valid after the strobes have been low long enough.
    logic [DW-1:0] mem [16];
    int  low_cnt = 0;
    logic model_en;
    assign model_en = !ce_n && !oe_n && we_n;
    assign dq = model_en ? ((low_cnt >= E_RD) ? mem[sram_addr] : ~mem[sram_addr]) : 'z;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Port monitor
    int rd_run = 0, wp_run = 0, rec_run = 0, oe_gap = 1000, wr_eps = 0;
    bit prev_we = 1, prev_oe = 1;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!ce_n && !oe_n) low_cnt <= low_cnt + 1; else low_cnt <= 0;
            if (!ce_n && !we_n) mem[sram_addr] <= dq;
            // R2 read window
            if (!ce_n && !oe_n) rd_run <= rd_run + 1;
            else if (rd_run != 0) begin
                check(rd_run == E_RD, "R2 read strobe width", rd_run, E_RD);
                rd_run <= 0;
            end
            // R4 turnaround
            if (!oe_n) oe_gap <= 0; else oe_gap <= oe_gap + 1;
            if (!we_n && prev_we) begin
                check(oe_gap >= E_TURN, "R4 read-to-write gap", oe_gap, E_TURN);
                wr_eps <= wr_eps + 1;
            end
            if (!we_n) begin
                if (!oe_n) check(0, "R5 oe low during write", 0, 1);
                wp_run <= wp_run + 1;
            end else if (wp_run != 0) begin
                check(wp_run == E_WP, "R5 write pulse width", wp_run, E_WP);
                check(!ce_n, "R6 ce low at write end", int'(ce_n), 0);
                wp_run <= 0;
                rec_run <= 1;
            end else if (rec_run != 0) begin
                if (!ce_n) rec_run <= rec_run + 1;
                else begin
                    check(rec_run == E_REC, "R6 recovery length", rec_run, E_REC);
                    rec_run <= 0;
                end
            end
            prev_we <= we_n;
            prev_oe <= oe_n;
        end
    end

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'(a * 37 + k * 11 + 5);
    endfunction

    task automatic op(input bit wr, input int a, input logic [DW-1:0] d,
                      input bit junk, input logic [DW-1:0] exp);
        int rv_at = -1, rdy_at = -1, rv_n = 0;
        while (!ready) @(negedge clk);
        req = 1; req_wr = wr; req_addr = AW'(a); req_wdata = d;
        for (int c = 1; c < 40 && rdy_at < 0; c++) begin
            @(negedge clk);
            if (c == 1) begin
                req = junk; req_wr = 1; req_addr = AW'(a + 7); req_wdata = 8'h5A;
            end else req = 0;
            if (c == 1) check(!ready, "R7 busy after accept", int'(ready), 0);
            if (rd_valid) begin
                rv_n++;
                if (rv_at < 0) rv_at = c;
            end
            if (ready) rdy_at = c;
        end
        req = 0;
        if (wr) begin
            check(rdy_at == E_WP + E_REC + 1, "R7 write busy time", rdy_at, E_WP + E_REC + 1);
            check(rv_n == 0, "R3 no valid on write", rv_n, 0);
        end else begin
            check(rv_at == E_RD + 1, "R3 valid timing", rv_at, E_RD + 1);
            check(rv_n == 1, "R3 single pulse", rv_n, 1);
            check(rdy_at == E_RD + E_TURN + 1, "R7 read busy time", rdy_at, E_RD + E_TURN + 1);
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; tests++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ce_n && oe_n && we_n, "R1 strobes high in reset", {ce_n, oe_n, we_n}, 7);
        check(ready && !rd_valid, "R1 ready/valid in reset", {ready, rd_valid}, 2);
        rst_n = 1;
        @(negedge clk);
        check(ce_n && oe_n && we_n && ready && !rd_valid, "R1 idle after reset",
              {ce_n, oe_n, we_n, ready, rd_valid}, 30);
        // Sweep: write all, read all
        for (int a = 0; a < 16; a++) op(1, a, pat(a, 0), 0, 0);
        for (int a = 0; a < 16; a++) begin
            op(0, a, 0, 0, 0);
            check(rd_data == pat(a, 0), "R3 read data", rd_data, pat(a, 0));
        end
        // Interleaved read->write and write->read
        for (int a = 0; a < 16; a++) begin
            op(0, a, 0, 0, 0);
            check(rd_data == pat(a, 0), "R3 read before rewrite", rd_data, pat(a, 0));
            op(1, a, pat(a, 1), 0, 0);
            op(0, a, 0, 0, 0);
            check(rd_data == pat(a, 1), "R5 rewritten data", rd_data, pat(a, 1));
        end
        // R7: request raised while busy is ignored
        begin
            int eps0;
            eps0 = wr_eps;
            op(1, 2, 8'hC3, 1, 0);
            repeat (4) @(negedge clk);
            check(wr_eps == eps0 + 1, "R7 busy request ignored (write count)", wr_eps, eps0 + 1);
            check(mem[9] == pat(9, 1), "R7 busy request ignored (memory)", mem[9], pat(9, 1));
            op(0, 2, 0, 1, 0);
            check(rd_data == 8'hC3, "R3 read after ignored", rd_data, 8'hC3);
            repeat (4) @(negedge clk);
            check(wr_eps == eps0 + 1, "R7 busy request during read ignored", wr_eps, eps0 + 1);
            op(0, 9, 0, 0, 0);
            check(rd_data == pat(9, 1), "R8 address held for whole read", rd_data, pat(9, 1));
        end
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule